// File: doc/BRIEF.md
# Command Recovery Timer

This block enforces a programmable quiet period after each card bus command. It watches four active-high command strobe inputs. When the last active strobe drops, it raises a recovery-busy flag for a programmed number of clock cycles. While that flag is high, new command requests are refused.

Two timing sets are held in two 8-bit registers, reached through a small indexed register port. A per-command select input chooses which set governs the recovery that follows the command. Each register packs a two-bit coarse weight and a six-bit multiplier. The recovery length is weight times multiplier plus one. One byte therefore covers lengths from a single cycle up to just over half a million cycles.

Top module: `cmdrec_timer`

## Requirements
- R1: Timing set 0 sits at register index 0x3C and timing set 1 at index 0x3F. A read of either index returns the full byte last written there.
- R2: Reads of any other index return 0x00. Writes to any other index change neither timing register.
- R3: After reset both timing registers read 0x03, so a recovery using either set lasts 4 cycles.
- R4: In a timing register, bits 7:6 pick a weight W (00 gives 1, 01 gives 16, 10 gives 256, 11 gives 8192) and bits 5:0 hold a multiplier M from 0 to 63. The recovery lasts W*M+1 clock cycles.
- R5: A multiplier of zero gives a recovery of exactly one cycle, whatever the weight.
- R6: A command end is a cycle in which no strobe is high although at least one was high in the previous cycle. The strobe bits are: bit 0 memory read enable, bit 1 memory write enable, bit 2 I/O read, bit 3 I/O write. `rec_busy` rises on the cycle after a command end and stays high for exactly the programmed number of cycles.
- R7: `set_sel` is sampled in the command-end cycle. Value 0 selects the register at 0x3C and value 1 selects the register at 0x3F.
- R8: A register write made during a recovery does not change the length of that recovery.
- R9: A command end that occurs while a recovery is running restarts the count. The new count has the full length of the set selected at that new end.
- R10: `cmd_accept` equals `cmd_req` while `rec_busy` is low and is 0 while `rec_busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_idx | input | 8 | Register index for reads and writes |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_idx` (combinational) |
| set_sel | input | 1 | Timing set used by the command now ending |
| strobes | input | 4 | Command strobes, active high (see R6) |
| cmd_req | input | 1 | Request to start a new command |
| cmd_accept | output | 1 | Request granted (not in recovery) |
| rec_busy | output | 1 | Recovery in progress |

## Verification
The only internal state is the two timing bytes and the recovery counter. A corrupted timing byte shows up at once on `reg_rdata` when its index is presented. It also shows up as a busy pulse of the wrong length after the next command that selects that set. A counter fault shows up within one recovery as a busy pulse that is too long, too short or missing. The same fault can also appear as a `cmd_accept` that opens early. The bench measures every busy pulse to the exact cycle. It does this for all four weights and for restarts, so an error of even one cycle is visible.

// File: rtl/cmdrec_pkg.sv
package cmdrec_pkg;
    localparam int REG_W   = 8;
    localparam int MULT_W  = 6;
    localparam int NSETS   = 2;
    localparam int SEL_W   = (NSETS > 1) ? $clog2(NSETS) : 1;
    localparam int MAX_LEN = 8192 * ((1 << MULT_W) - 1) + 1;
    localparam int CNT_W   = $clog2(MAX_LEN + 1);

    localparam logic [REG_W-1:0] IDX_SET0 = 8'h3C;
    localparam logic [REG_W-1:0] IDX_SET1 = 8'h3F;
    localparam logic [REG_W-1:0] RST_VAL  = 8'h03;

    typedef enum logic [1:0] {
        WT_1    = 2'b00,
        WT_16   = 2'b01,
        WT_256  = 2'b10,
        WT_8192 = 2'b11
    } weight_e;

    typedef struct packed {
        weight_e           weight;
        logic [MULT_W-1:0] mult;
    } rec_cfg_t;

    typedef logic [CNT_W-1:0] cnt_t;

    function automatic logic [REG_W-1:0] set_index(int s);
        return (s == 0) ? IDX_SET0 : IDX_SET1;
    endfunction

    function automatic cnt_t rec_length(rec_cfg_t c);
        cnt_t base;
        cnt_t scaled;
        base = cnt_t'(c.mult);
        case (c.weight)
            WT_1:    scaled = base;
            WT_16:   scaled = base << 4;
            WT_256:  scaled = base << 8;
            default: scaled = base << 13;
        endcase
        return scaled + cnt_t'(1);
    endfunction
endpackage

// File: rtl/cmdrec_regs.sv
module cmdrec_regs
    import cmdrec_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [REG_W-1:0]            idx,
    input  logic                        we,
    input  logic [REG_W-1:0]            wdata,
    output logic [REG_W-1:0]            rdata,
    output rec_cfg_t [NSETS-1:0]        cfg
);
    for (genvar s = 0; s < NSETS; s++) begin : g_set
        always_ff @(posedge clk) begin
            if (rst)
                cfg[s] <= rec_cfg_t'(RST_VAL);
            else if (we && idx == set_index(s))
                cfg[s] <= rec_cfg_t'(wdata);
        end
    end

    always_comb begin
        rdata = '0;
        for (int s = 0; s < NSETS; s++)
            if (idx == set_index(s))
                rdata = REG_W'(cfg[s]);
    end
endmodule

// File: rtl/cmdrec_end_det.sv
module cmdrec_end_det #(
    parameter int NSTROBE = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSTROBE-1:0] strobes,
    output logic               end_pulse
);
    logic any_now;
    logic any_prev;

    assign any_now = |strobes;

    always_ff @(posedge clk) begin
        if (rst) any_prev <= 1'b0;
        else     any_prev <= any_now;
    end

    assign end_pulse = any_prev & ~any_now;
endmodule

// File: rtl/cmdrec_counter.sv
module cmdrec_counter
    import cmdrec_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  cnt_t load_val,
    output logic busy
);
    cnt_t remain;

    always_ff @(posedge clk) begin
        if (rst)
            remain <= '0;
        else if (load)
            remain <= load_val;
        else if (remain != '0)
            remain <= remain - cnt_t'(1);
    end

    assign busy = (remain != '0);
endmodule

// File: rtl/cmdrec_timer.sv
module cmdrec_timer
    import cmdrec_pkg::*;
#(
    parameter int NSTROBE = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [REG_W-1:0]   reg_idx,
    input  logic               reg_we,
    input  logic [REG_W-1:0]   reg_wdata,
    output logic [REG_W-1:0]   reg_rdata,
    input  logic [SEL_W-1:0]   set_sel,
    input  logic [NSTROBE-1:0] strobes,
    input  logic               cmd_req,
    output logic               cmd_accept,
    output logic               rec_busy
);
    rec_cfg_t [NSETS-1:0] cfg;
    rec_cfg_t             cur_cfg;
    cnt_t                 cur_len;
    logic                 end_pulse;

    cmdrec_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .idx   (reg_idx),
        .we    (reg_we),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .cfg   (cfg)
    );

    cmdrec_end_det #(.NSTROBE(NSTROBE)) u_end (
        .clk       (clk),
        .rst       (rst),
        .strobes   (strobes),
        .end_pulse (end_pulse)
    );

    assign cur_cfg = cfg[set_sel];
    assign cur_len = rec_length(cur_cfg);

    cmdrec_counter u_cnt (
        .clk      (clk),
        .rst      (rst),
        .load     (end_pulse),
        .load_val (cur_len),
        .busy     (rec_busy)
    );

    assign cmd_accept = cmd_req & ~rec_busy;
endmodule

// File: rtl/cmdrec_timer_chk.sv
module cmdrec_timer_chk
    import cmdrec_pkg::*;
#(
    parameter int NSTROBE = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [REG_W-1:0]   reg_idx,
    input logic               reg_we,
    input logic [REG_W-1:0]   reg_wdata,
    input logic [REG_W-1:0]   reg_rdata,
    input logic [SEL_W-1:0]   set_sel,
    input logic [NSTROBE-1:0] strobes,
    input logic               cmd_req,
    input logic               cmd_accept,
    input logic               rec_busy
);
    // R6: busy follows a command end by one cycle
    p_busy_after_end_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(|strobes) |=> rec_busy);

    // R10: no grant during recovery
    p_no_grant_busy_r10: assert property (@(posedge clk) disable iff (rst)
        rec_busy |-> !cmd_accept);

    // R2: unmapped indexes read zero
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_idx != IDX_SET0 && reg_idx != IDX_SET1) |-> reg_rdata == '0);

    // R1: written byte reads back on the following cycle
    p_readback_r1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(reg_we) && $past(reg_idx) == IDX_SET0 && reg_idx == IDX_SET0)
        |-> reg_rdata == $past(reg_wdata));

    // R3: reset value visible right after reset
    p_reset_val_r3: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && reg_idx == IDX_SET1) |-> reg_rdata == RST_VAL);
endmodule

bind cmdrec_timer cmdrec_timer_chk #(.NSTROBE(NSTROBE)) u_chk (.*);

// File: tb/cmdrec_timer_bench.sv
`timescale 1ns/1ps
module cmdrec_timer_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] reg_idx;
    logic       reg_we;
    logic [7:0] reg_wdata;
    logic [7:0] reg_rdata;
    logic       set_sel;
    logic [3:0] strobes;
    logic       cmd_req;
    logic       cmd_accept;
    logic       rec_busy;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    logic [7:0] shadow [2];

    always #2.5 clk = ~clk;

    cmdrec_timer u_cmdrec_timer (
        .clk(clk), .rst(rst), .reg_idx(reg_idx), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .set_sel(set_sel),
        .strobes(strobes), .cmd_req(cmd_req), .cmd_accept(cmd_accept),
        .rec_busy(rec_busy)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            fails++;
            $display("FAIL watchdog: run exceeded cycle limit act=%0d exp<=200000", cycles);
            $display("  [TB] %0d tests run, %0d failed", tests + 1, fails);
            $finish;
        end
    end

    function automatic int exp_len(logic [7:0] b);
        int w;
        case (b[7:6])
            2'b00:   w = 1;
            2'b01:   w = 16;
            2'b10:   w = 256;
            default: w = 8192;
        endcase
        return w * int'(b[5:0]) + 1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic wr(logic [7:0] idx, logic [7:0] d);
        @(negedge clk);
        reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        if (idx == 8'h3C) shadow[0] = d;
        if (idx == 8'h3F) shadow[1] = d;
    endtask

    task automatic rd_check(logic [7:0] idx, logic [7:0] exp, string req);
        reg_idx = idx;
        #0.5;
        check(reg_rdata == exp, req, reg_rdata, exp);
    endtask

    // Count busy cycles, starting at the negedge right after the end edge.
    // If do_wr is set, a write to the active set is made during the recovery.
    task automatic measure(bit do_wr, logic [7:0] idx, logic [7:0] d, output int n);
        n = 0;
        while (rec_busy && n < 600000) begin
            n++;
            if (do_wr && n == 1) begin
                reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
            end
            @(negedge clk);
            if (do_wr && n == 1) begin
                reg_we = 1'b0;
                if (idx == 8'h3C) shadow[0] = d;
                if (idx == 8'h3F) shadow[1] = d;
            end
        end
    endtask

    // Drive one command on strobe bit b with set s; returns at the first negedge after the end edge.
    task automatic run_cmd(logic s, int b, string req, bit chk_idle);
        @(negedge clk);
        strobes = 4'b1 << b; set_sel = s;
        @(negedge clk);
        @(negedge clk);
        strobes = 4'b0;
        #0.5;
        if (chk_idle) check(rec_busy == 1'b0, req, rec_busy, 0);
        @(negedge clk);
    endtask

    initial begin
        int n;
        int exp;
        logic [7:0] v;
        void'($urandom(32'h5eed_1234));
        rst = 1'b1; reg_idx = 8'h3C; reg_we = 1'b0; reg_wdata = 8'h00;
        set_sel = 1'b0; strobes = 4'b0; cmd_req = 1'b0;
        shadow[0] = 8'h03; shadow[1] = 8'h03;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R3: reset values and default length
        rd_check(8'h3C, 8'h03, "R3");
        rd_check(8'h3F, 8'h03, "R3");
        check(rec_busy == 1'b0, "R3", rec_busy, 0);
        run_cmd(1'b0, 0, "R6", 1'b1);
        measure(1'b0, 8'h00, 8'h00, n);
        check(n == 4, "R3", n, 4);
        run_cmd(1'b1, 3, "R6", 1'b1);
        measure(1'b0, 8'h00, 8'h00, n);
        check(n == 4, "R3", n, 4);

        // R1 / R2: readback and unmapped indexes
        wr(8'h3C, 8'hA5);
        rd_check(8'h3C, 8'hA5, "R1");
        wr(8'h3F, 8'h5A);
        rd_check(8'h3F, 8'h5A, "R1");
        wr(8'h3D, 8'hFF);
        rd_check(8'h3D, 8'h00, "R2");
        rd_check(8'h3C, 8'hA5, "R2");
        rd_check(8'h3F, 8'h5A, "R2");
        wr(8'h00, 8'h77);
        rd_check(8'h00, 8'h00, "R2");
        rd_check(8'h3C, 8'hA5, "R2");

        // R5: zero multiplier, each weight
        for (int w = 0; w < 4; w++) begin
            wr(8'h3C, 8'(w << 6));
            run_cmd(1'b0, w, "R6", 1'b1);
            measure(1'b0, 8'h00, 8'h00, n);
            check(n == 1, "R5", n, 1);
        end

        // R4: large weights, directed
        wr(8'h3F, 8'hBF);
        run_cmd(1'b1, 1, "R6", 1'b1);
        measure(1'b0, 8'h00, 8'h00, n);
        check(n == 16129, "R4", n, 16129);
        wr(8'h3C, 8'hC1);
        run_cmd(1'b0, 2, "R6", 1'b1);
        measure(1'b0, 8'h00, 8'h00, n);
        check(n == 8193, "R4", n, 8193);

        // R7: set select picks the register
        wr(8'h3C, 8'h05);
        wr(8'h3F, 8'h49);
        run_cmd(1'b0, 1, "R7", 1'b1);
        measure(1'b0, 8'h00, 8'h00, n);
        check(n == 6, "R7", n, 6);
        run_cmd(1'b1, 1, "R7", 1'b1);
        measure(1'b0, 8'h00, 8'h00, n);
        check(n == 16 * 9 + 1, "R7", n, 16 * 9 + 1);

        // R8: write during recovery does not alter it
        run_cmd(1'b0, 2, "R8", 1'b1);
        measure(1'b1, 8'h3C, 8'h3F, n);
        check(n == 6, "R8", n, 6);
        rd_check(8'h3C, 8'h3F, "R8");

        // R10: grant gating
        cmd_req = 1'b1;
        #0.5;
        check(cmd_accept == 1'b1, "R10", cmd_accept, 1);
        run_cmd(1'b0, 3, "R10", 1'b1);
        #0.5;
        check(cmd_accept == 1'b0, "R10", cmd_accept, 0);
        measure(1'b0, 8'h00, 8'h00, n);
        #0.5;
        check(cmd_accept == 1'b1, "R10", cmd_accept, 1);
        cmd_req = 1'b0;
        #0.5;
        check(cmd_accept == 1'b0, "R10", cmd_accept, 0);

        // R9: restart during recovery with the other set
        wr(8'h3C, 8'h45);
        wr(8'h3F, 8'h07);
        run_cmd(1'b0, 0, "R9", 1'b1);
        repeat (10) @(negedge clk);
        check(rec_busy == 1'b1, "R9", rec_busy, 1);
        run_cmd(1'b1, 2, "R9", 1'b0);
        measure(1'b0, 8'h00, 8'h00, n);
        check(n == 8, "R9", n, 8);

        // R4 / R6: random settings, sets and strobes
        for (int i = 0; i < 24; i++) begin
            logic s;
            int b;
            v = 8'($urandom());
            v[7] = 1'b0;
            s = 1'($urandom());
            b = int'($urandom() % 4);
            wr(s ? 8'h3F : 8'h3C, v);
            rd_check(s ? 8'h3F : 8'h3C, v, "R1");
            run_cmd(s, b, "R6", 1'b1);
            measure(1'b0, 8'h00, 8'h00, n);
            exp = exp_len(shadow[s]);
            check(n == exp, "R4", n, exp);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule